// File: doc/BRIEF.md
# RTC Clock Operation Sequencer

This block turns three whole-clock host commands into the chains of single-nibble register accesses that a serial real-time-clock device needs. It sits between a host and a serial bus master. It owns the device's chip-enable line and issues one register read or write at a time on its lower side. Each request is held until the bus master acknowledges it. On that same cycle the bus master returns the read nibble.

A time read or time write first sets 24-hour mode and checks the device's busy flag. While the flag is set, chip-enable is dropped for a programmable gap and the handshake is tried again, up to a retry limit. After that, the seven calendar fields move as packed two-digit BCD bytes, each split over a units register and a tens register. The power-up check looks for the oscillator-stop flag. When the flag is set, the block turns off the periodic-interrupt register, restarts the oscillator, waits for the busy flag to clear, and loads a default date. Conversion to binary and calendar validation are left to the host.

Top module: `rtc_seq_top`

## Requirements
- R1: Out of reset and whenever `busy` is low, `rtc_ce`, `done` and `bus_req` are low.
- R2: Only one operation runs at a time, and start inputs are ignored while `busy` is high. When several starts arrive together, check wins over write, and write wins over read. `done` is high for exactly one cycle, with `busy` low, at the end of each operation. `op_error` and `reset_occurred` keep their values until the next start.
- R3: A time read or time write raises `rtc_ce`, writes 0x4 to control address 0xE, and then reads address 0xE.
- R4: If bit 0 (busy) of that control read is 1, `rtc_ce` is held low for at least `CE_LOW_CYCLES` cycles. The write-0x4 / read-0xE handshake is then repeated.
- R5: After `RETRY_LIMIT` busy reads in one operation, the operation ends without touching any time register. `rtc_ce` drops and `done` comes with `op_error` = 1.
- R6: Field accesses use the addresses 0x0,0x1,0x2,0x3,0x4,0x5,0x8,0x9,0xA,0xB,0xC,0xD,0x6. These are seconds, minutes, hours, day, month and year, each as units then tens, followed by weekday.
- R7: On a read, each 8-bit output is the tens nibble in bits 7:4 and the units nibble in bits 3:0. `rd_wday` is the nibble read at 0x6.
- R8: On a write, bits 3:0 of each input go to the units address and bits 7:4 go to the tens address. `wr_wday` goes to 0x6.
- R9: After the last access, `rtc_ce` is low for at least `CE_LOW_CYCLES` cycles before `done`.
- R10: A check raises `rtc_ce` and reads 0xE. If bit 1 (oscillator stop) is 0, it ends with `reset_occurred` = 0 and no further access.
- R11: If bit 1 is 1, the check does the following with `rtc_ce` high throughout. It writes 0x0 to 0x7, then 0x7 to 0xE. It reads 0xE until bit 0 is 0. It then writes seconds, minutes, hours and year as 00, day `DEF_DAY`, month `DEF_MON` and weekday 0 in the R6 order. It ends with `reset_occurred` = 1.
- R12: `bus_req` is only high while `rtc_ce` is high. Address, direction and write data stay stable until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_read | input | 1 | Begin a time read |
| start_write | input | 1 | Begin a time write |
| start_check | input | 1 | Begin the power-up validity check |
| wr_sec | input | 8 | BCD seconds to write |
| wr_min | input | 8 | BCD minutes to write |
| wr_hour | input | 8 | BCD hours to write |
| wr_day | input | 8 | BCD day of month to write |
| wr_mon | input | 8 | BCD month to write |
| wr_year | input | 8 | BCD year to write |
| wr_wday | input | 4 | Weekday to write |
| rd_sec | output | 8 | BCD seconds read |
| rd_min | output | 8 | BCD minutes read |
| rd_hour | output | 8 | BCD hours read |
| rd_day | output | 8 | BCD day read |
| rd_mon | output | 8 | BCD month read |
| rd_year | output | 8 | BCD year read |
| rd_wday | output | 4 | Weekday read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| op_error | output | 1 | Last operation hit the retry limit |
| reset_occurred | output | 1 | Last check restarted the clock |
| rtc_ce | output | 1 | Device chip-enable |
| bus_req | output | 1 | Single-register request to the bus master |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | 4 | Register address |
| bus_wdata | output | 4 | Nibble to write |
| bus_ack | input | 1 | Request accepted; read data valid |
| bus_rdata | input | 4 | Nibble read |

## Verification
The bench holds the busy flag set for a number of control reads. A design that skipped the chip-enable gap, or that went on to the time registers, would show a short low run or a stream of accesses that does not match. Holding busy past the retry limit checks that the block aborts, rather than polling forever or touching a field. A design that swapped units and tens, or that used the wrong field order, gives wrong nibbles in the device model and wrong packed outputs. Starts sent mid-operation, and two starts in one cycle, catch a second launch or the wrong priority. The stop-flag path with a busy restart catches a missing poll or a wrong default date.

// File: rtl/rtc_seq_pkg.sv
`timescale 1ns/1ps
package rtc_seq_pkg;
   localparam int NIB_W      = 4;
   localparam int FLD_W      = 8;
   localparam int NUM_FIELDS = 7;
   localparam int NUM_STEPS  = 13;
   localparam int STEP_W     = 4;
   localparam int FIELD_W    = 3;

   localparam logic [NIB_W-1:0] A_CTL       = 4'hE;
   localparam logic [NIB_W-1:0] A_INTV      = 4'h7;
   localparam logic [NIB_W-1:0] CTL_MODE24  = 4'h4;
   localparam logic [NIB_W-1:0] CTL_RESTART = 4'h7;
   localparam logic [NIB_W-1:0] INTV_OFF    = 4'h0;
   localparam int B_BUSY = 0;
   localparam int B_STOP = 1;

   typedef enum logic [3:0] {
      ST_IDLE, ST_CTL_WR, ST_CTL_RD, ST_GAP, ST_XFER,
      ST_CHK_RD, ST_INT_WR, ST_ADJ_WR, ST_POLL_RD, ST_TAIL
   } seq_state_t;

   typedef enum logic [1:0] {OP_READ, OP_WRITE, OP_CHECK} seq_op_t;

   typedef struct packed {
      logic [NIB_W-1:0]   addr;
      logic               tens;
      logic [FIELD_W-1:0] field;
      logic               last;
   } step_info_t;
endpackage

// File: rtl/rtc_seq_plan.sv
`timescale 1ns/1ps
module rtc_seq_plan
   import rtc_seq_pkg::*;
(
   input  logic [STEP_W-1:0] step,
   output step_info_t        info
);
   logic [FIELD_W-1:0] fld;
   logic               hi;
   logic [NIB_W-1:0]   base;

   always_comb begin
      if (step < STEP_W'(NUM_STEPS - 1)) begin
         fld = step[3:1];
         hi  = step[0];
      end else begin
         fld = FIELD_W'(NUM_FIELDS - 1);
         hi  = 1'b0;
      end
      case (fld)
         3'd0:    base = 4'h0;
         3'd1:    base = 4'h2;
         3'd2:    base = 4'h4;
         3'd3:    base = 4'h8;
         3'd4:    base = 4'hA;
         3'd5:    base = 4'hC;
         default: base = 4'h6;
      endcase
      info.addr  = base | {3'b000, hi};
      info.tens  = hi;
      info.field = fld;
      info.last  = (step == STEP_W'(NUM_STEPS - 1));
   end
endmodule

// File: rtl/rtc_seq_timer.sv
`timescale 1ns/1ps
module rtc_seq_timer #(
   parameter int CYCLES = 140
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic fin
);
   localparam int W = $clog2(CYCLES + 1);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= W'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign fin = (cnt == W'(1));
endmodule

// File: rtl/rtc_seq_retry.sv
`timescale 1ns/1ps
module rtc_seq_retry #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bump,
   output logic last
);
   localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (bump)  cnt <= cnt + 1'b1;
   end

   assign last = (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/rtc_seq_top.sv
`timescale 1ns/1ps
module rtc_seq_top
   import rtc_seq_pkg::*;
#(
   parameter int         CE_LOW_CYCLES = 140,
   parameter int         RETRY_LIMIT   = 4,
   parameter logic [7:0] DEF_DAY       = 8'h01,
   parameter logic [7:0] DEF_MON       = 8'h01
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_read,
   input  logic       start_write,
   input  logic       start_check,
   input  logic [7:0] wr_sec,
   input  logic [7:0] wr_min,
   input  logic [7:0] wr_hour,
   input  logic [7:0] wr_day,
   input  logic [7:0] wr_mon,
   input  logic [7:0] wr_year,
   input  logic [3:0] wr_wday,
   output logic [7:0] rd_sec,
   output logic [7:0] rd_min,
   output logic [7:0] rd_hour,
   output logic [7:0] rd_day,
   output logic [7:0] rd_mon,
   output logic [7:0] rd_year,
   output logic [3:0] rd_wday,
   output logic       busy,
   output logic       done,
   output logic       op_error,
   output logic       reset_occurred,
   output logic       rtc_ce,
   output logic       bus_req,
   output logic       bus_we,
   output logic [3:0] bus_addr,
   output logic [3:0] bus_wdata,
   input  logic       bus_ack,
   input  logic [3:0] bus_rdata
);
   generate
      if (CE_LOW_CYCLES < 1) begin : g_bad_gap
         $error("CE_LOW_CYCLES must be at least 1");
      end
      if (RETRY_LIMIT < 1) begin : g_bad_retry
         $error("RETRY_LIMIT must be at least 1");
      end
      if (DEF_DAY[3:0] > 4'd9 || DEF_MON[3:0] > 4'd9) begin : g_bad_bcd
         $error("default date must be BCD");
      end
   endgenerate

   seq_state_t       state;
   seq_op_t          op;
   logic [STEP_W-1:0] step;
   logic             ce_q, done_q, err_q, rst_occ_q;
   logic [FLD_W-1:0] src [0:NUM_FIELDS-1];
   step_info_t       info;
   logic             tmr_start, tmr_fin;
   logic             rty_clr, rty_bump, rty_last;
   logic             any_start, cap;
   logic [FLD_W-1:0] sel;

   rtc_seq_plan u_plan (.step(step), .info(info));

   rtc_seq_timer #(.CYCLES(CE_LOW_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .fin(tmr_fin));

   rtc_seq_retry #(.LIMIT(RETRY_LIMIT)) u_rty (
      .clk(clk), .rst_n(rst_n), .clr(rty_clr), .bump(rty_bump), .last(rty_last));

   assign any_start = start_read | start_write | start_check;
   assign sel       = src[info.field];
   assign cap       = (state == ST_XFER) && bus_ack && (op == OP_READ);

   // gap/tail timer and retry counter controls
   always_comb begin
      tmr_start = 1'b0;
      rty_bump  = 1'b0;
      rty_clr   = (state == ST_IDLE);
      if (bus_ack) begin
         case (state)
            ST_CTL_RD: begin
               tmr_start = bus_rdata[B_BUSY];
               rty_bump  = bus_rdata[B_BUSY];
            end
            ST_POLL_RD: begin
               tmr_start = bus_rdata[B_BUSY] && rty_last;
               rty_bump  = bus_rdata[B_BUSY];
            end
            ST_XFER:   tmr_start = info.last;
            ST_CHK_RD: tmr_start = !bus_rdata[B_STOP];
            default: ;
         endcase
      end
   end

   // request to the bus master
   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = A_CTL;
      bus_wdata = '0;
      case (state)
         ST_CTL_WR: begin
            bus_req = 1'b1; bus_we = 1'b1; bus_wdata = CTL_MODE24;
         end
         ST_CTL_RD, ST_CHK_RD, ST_POLL_RD: bus_req = 1'b1;
         ST_INT_WR: begin
            bus_req = 1'b1; bus_we = 1'b1; bus_addr = A_INTV; bus_wdata = INTV_OFF;
         end
         ST_ADJ_WR: begin
            bus_req = 1'b1; bus_we = 1'b1; bus_wdata = CTL_RESTART;
         end
         ST_XFER: begin
            bus_req   = 1'b1;
            bus_we    = (op != OP_READ);
            bus_addr  = info.addr;
            bus_wdata = info.tens ? sel[7:4] : sel[3:0];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op        <= OP_READ;
         step      <= '0;
         ce_q      <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         rst_occ_q <= 1'b0;
         for (int i = 0; i < NUM_FIELDS; i++) src[i] <= '0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: if (any_start) begin
               ce_q      <= 1'b1;
               err_q     <= 1'b0;
               rst_occ_q <= 1'b0;
               step      <= '0;
               src[0] <= start_check ? 8'h00   : wr_sec;
               src[1] <= start_check ? 8'h00   : wr_min;
               src[2] <= start_check ? 8'h00   : wr_hour;
               src[3] <= start_check ? DEF_DAY : wr_day;
               src[4] <= start_check ? DEF_MON : wr_mon;
               src[5] <= start_check ? 8'h00   : wr_year;
               src[6] <= start_check ? 8'h00   : {4'h0, wr_wday};
               if (start_check) begin
                  op    <= OP_CHECK;
                  state <= ST_CHK_RD;
               end else begin
                  op    <= start_write ? OP_WRITE : OP_READ;
                  state <= ST_CTL_WR;
               end
            end
            ST_CTL_WR: if (bus_ack) state <= ST_CTL_RD;
            ST_CTL_RD: if (bus_ack) begin
               if (!bus_rdata[B_BUSY]) begin
                  state <= ST_XFER;
               end else begin
                  ce_q  <= 1'b0;
                  err_q <= rty_last;
                  state <= rty_last ? ST_TAIL : ST_GAP;
               end
            end
            ST_GAP: if (tmr_fin) begin
               ce_q  <= 1'b1;
               state <= ST_CTL_WR;
            end
            ST_XFER: if (bus_ack) begin
               if (info.last) begin
                  ce_q      <= 1'b0;
                  rst_occ_q <= (op == OP_CHECK);
                  state     <= ST_TAIL;
               end else begin
                  step <= step + 1'b1;
               end
            end
            ST_CHK_RD: if (bus_ack) begin
               if (bus_rdata[B_STOP]) begin
                  state <= ST_INT_WR;
               end else begin
                  ce_q  <= 1'b0;
                  state <= ST_TAIL;
               end
            end
            ST_INT_WR: if (bus_ack) state <= ST_ADJ_WR;
            ST_ADJ_WR: if (bus_ack) state <= ST_POLL_RD;
            ST_POLL_RD: if (bus_ack) begin
               if (!bus_rdata[B_BUSY]) begin
                  state <= ST_XFER;
               end else if (rty_last) begin
                  ce_q  <= 1'b0;
                  err_q <= 1'b1;
                  state <= ST_TAIL;
               end
            end
            ST_TAIL: if (tmr_fin) begin
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // read capture, one register per field
   logic [FLD_W-1:0] fld_q [0:NUM_FIELDS-1];
   generate
      for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
         logic [FLD_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (cap && info.field == FIELD_W'(f))
               q <= info.tens ? {bus_rdata, q[3:0]} : {4'h0, bus_rdata};
         end
         assign fld_q[f] = q;
      end
   endgenerate

   assign rd_sec         = fld_q[0];
   assign rd_min         = fld_q[1];
   assign rd_hour        = fld_q[2];
   assign rd_day         = fld_q[3];
   assign rd_mon         = fld_q[4];
   assign rd_year        = fld_q[5];
   assign rd_wday        = fld_q[6][3:0];
   assign busy           = (state != ST_IDLE);
   assign done           = done_q;
   assign op_error       = err_q;
   assign reset_occurred = rst_occ_q;
   assign rtc_ce         = ce_q;
endmodule

// File: rtl/rtc_seq_chk.sv
`timescale 1ns/1ps
module rtc_seq_chk #(
   parameter int CE_LOW_CYCLES = 140
) (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       rtc_ce,
   input logic       bus_req,
   input logic       bus_we,
   input logic [3:0] bus_addr,
   input logic [3:0] bus_wdata,
   input logic       bus_ack
);
   localparam int LW = $clog2(CE_LOW_CYCLES + 2);
   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          low_cnt <= '0;
      else if (rtc_ce || !busy)            low_cnt <= '0;
      else if (low_cnt != LW'(CE_LOW_CYCLES + 1)) low_cnt <= low_cnt + 1'b1;
   end

   AST_IDLE_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rtc_ce && !bus_req)); // R1
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R2
   AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rtc_ce) && $past(busy)) |-> (low_cnt >= LW'(CE_LOW_CYCLES))); // R4
   AST_TAIL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (low_cnt >= LW'(CE_LOW_CYCLES))); // R9
   AST_REQ_CE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> rtc_ce); // R12
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_wdata))); // R12
endmodule

bind rtc_seq_top rtc_seq_chk #(.CE_LOW_CYCLES(CE_LOW_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rtc_ce(rtc_ce),
   .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_ack(bus_ack));

// File: tb/sim_rtc_seq_top.sv
`timescale 1ns/1ps
module sim_rtc_seq_top;
   localparam int GAP = 140;
   localparam int LIM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_read = 0, start_write = 0, start_check = 0;
   logic [7:0] wr_sec = 0, wr_min = 0, wr_hour = 0, wr_day = 0, wr_mon = 0, wr_year = 0;
   logic [3:0] wr_wday = 0;
   logic [7:0] rd_sec, rd_min, rd_hour, rd_day, rd_mon, rd_year;
   logic [3:0] rd_wday;
   logic busy, done, op_error, reset_occurred, rtc_ce;
   logic bus_req, bus_we;
   logic [3:0] bus_addr, bus_wdata;
   logic bus_ack = 1'b0;
   logic [3:0] bus_rdata = 4'h0;

   always #2.5 clk = ~clk;

   rtc_seq_top #(.CE_LOW_CYCLES(GAP), .RETRY_LIMIT(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .start_read(start_read), .start_write(start_write),
      .start_check(start_check), .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour),
      .wr_day(wr_day), .wr_mon(wr_mon), .wr_year(wr_year), .wr_wday(wr_wday),
      .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_day(rd_day),
      .rd_mon(rd_mon), .rd_year(rd_year), .rd_wday(rd_wday), .busy(busy), .done(done),
      .op_error(op_error), .reset_occurred(reset_occurred), .rtc_ce(rtc_ce),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata));

   int n_chk = 0, n_fail = 0;
   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // device model: 16 nibbles, busy flag countdown, oscillator-stop flag
   logic [3:0] mreg [0:15];
   int busy_left = 0;
   int adj_busy = 0;
   logic xstp = 1'b0;
   int dly = 2;

   always @(posedge clk) begin
      if (!rst_n) begin
         bus_ack <= 1'b0;
         dly     <= 2;
      end else if (bus_ack) begin
         bus_ack <= 1'b0;
      end else if (bus_req) begin
         if (dly == 0) begin
            bus_ack <= 1'b1;
            dly     <= 2;
            if (bus_we) begin
               mreg[bus_addr] <= bus_wdata;
               if (bus_addr == 4'hE && bus_wdata == 4'h7) begin
                  busy_left <= adj_busy;
                  xstp      <= 1'b0;
               end
            end else if (bus_addr == 4'hE) begin
               bus_rdata <= {mreg[14][3:2], xstp, (busy_left > 0)};
               if (busy_left > 0) busy_left <= busy_left - 1;
            end else begin
               bus_rdata <= mreg[bus_addr];
            end
         end else begin
            dly <= dly - 1;
         end
      end
   end

   // scoreboard of expected bus accesses {we, addr, wdata}
   logic [8:0] exp_q [$];
   int done_seen = 0, gaps_seen = 0, lowrun = 0;
   logic prev_ce = 1'b0, prev_busy = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_req && bus_ack) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6 unexpected bus access", {bus_we, bus_addr, bus_wdata}, 0);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk(bus_we == e[8] && bus_addr == e[7:4] && (!e[8] || bus_wdata == e[3:0]),
                   "R6 access order/content", {bus_we, bus_addr, bus_wdata}, e);
            end
         end
         if (!prev_ce && rtc_ce && prev_busy) begin
            gaps_seen++;
            chk(lowrun >= GAP, "R4 CE low gap", lowrun, GAP);
         end
         if (done) begin
            done_seen++;
            chk(lowrun >= GAP, "R9 CE low before done", lowrun, GAP);
         end
         if (rtc_ce || !busy) lowrun = 0;
         else lowrun++;
         prev_ce   = rtc_ce;
         prev_busy = busy;
      end
   end

   function automatic logic [3:0] step_addr(input int i);
      logic [3:0] b;
      if (i == 12) return 4'h6;
      case (i / 2)
         0: b = 4'h0; 1: b = 4'h2; 2: b = 4'h4;
         3: b = 4'h8; 4: b = 4'hA; default: b = 4'hC;
      endcase
      return b | 4'(i % 2);
   endfunction

   task automatic push(input bit we, input logic [3:0] a, input logic [3:0] d);
      exp_q.push_back({we, a, d});
   endtask
   task automatic push_pre();
      push(1, 4'hE, 4'h4);
      push(0, 4'hE, 4'h0);
   endtask
   task automatic push_reads();
      for (int i = 0; i < 13; i++) push(0, step_addr(i), 4'h0);
   endtask
   task automatic push_writes(input logic [7:0] s, mi, h, d, mo, y, input logic [3:0] w);
      logic [7:0] b [0:6];
      b[0] = s; b[1] = mi; b[2] = h; b[3] = d; b[4] = mo; b[5] = y; b[6] = {4'h0, w};
      for (int i = 0; i < 13; i++) begin
         int f;
         f = (i == 12) ? 6 : i / 2;
         push(1, step_addr(i), (i % 2 == 1) ? b[f][7:4] : b[f][3:0]);
      end
   endtask

   task automatic set_wr(input logic [7:0] s, mi, h, d, mo, y, input logic [3:0] w);
      wr_sec = s; wr_min = mi; wr_hour = h; wr_day = d; wr_mon = mo; wr_year = y; wr_wday = w;
   endtask

   task automatic wait_done(input string tag);
      int n;
      n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(done, {tag, " done reached"}, done, 1);
   endtask

   task automatic run_op(input bit rd, input bit wr, input bit ck, input string tag);
      @(negedge clk);
      start_read = rd; start_write = wr; start_check = ck;
      @(negedge clk);
      start_read = 0; start_write = 0; start_check = 0;
      wait_done(tag);
      @(negedge clk);
      chk(!done && !busy, "R2 done is a single idle-cycle pulse", done, 0);
      chk(exp_q.size() == 0, {tag, " all expected accesses seen"}, exp_q.size(), 0);
   endtask

   initial begin
      #(5.0 * 190000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int d0;
      for (int i = 0; i < 16; i++) mreg[i] = 4'h0;
      repeat (4) @(negedge clk);
      chk(!rtc_ce && !busy && !done && !bus_req, "R1 reset state",
          {rtc_ce, busy, done, bus_req}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!rtc_ce && !bus_req, "R1 idle after reset", {rtc_ce, bus_req}, 0);

      // R3 R6 R7: plain read
      mreg[0] = 4'h3; mreg[1] = 4'h5; mreg[2] = 4'h7; mreg[3] = 4'h4;
      mreg[4] = 4'h2; mreg[5] = 4'h1; mreg[8] = 4'h9; mreg[9] = 4'h2;
      mreg[10] = 4'h2; mreg[11] = 4'h1; mreg[12] = 4'h9; mreg[13] = 4'h9;
      mreg[6] = 4'h5;
      push_pre(); push_reads();
      run_op(1, 0, 0, "R3");
      chk(rd_sec == 8'h53 && rd_min == 8'h47 && rd_hour == 8'h12, "R7 read packing sec/min/hour",
          {rd_sec, rd_min, rd_hour}, 32'h534712);
      chk(rd_day == 8'h29 && rd_mon == 8'h12 && rd_year == 8'h99 && rd_wday == 4'h5,
          "R7 read packing day/mon/year/wday", {rd_day, rd_mon, rd_year, rd_wday}, 32'h2912995);
      chk(!op_error, "R5 no error when never busy", op_error, 0);

      // R8: write
      set_wr(8'h59, 8'h08, 8'h23, 8'h31, 8'h07, 8'h24, 4'h6);
      push_pre(); push_writes(8'h59, 8'h08, 8'h23, 8'h31, 8'h07, 8'h24, 4'h6);
      run_op(0, 1, 0, "R8");
      chk(mreg[0] == 4'h9 && mreg[1] == 4'h5 && mreg[9] == 4'h3 && mreg[8] == 4'h1
          && mreg[13] == 4'h2 && mreg[6] == 4'h6, "R8 nibble split in device",
          {mreg[0], mreg[1], mreg[8], mreg[9], mreg[13], mreg[6]}, 24'h951326);

      // R4: busy twice, then read back the written pattern
      busy_left = 2;
      d0 = gaps_seen;
      push_pre(); push_pre(); push_pre(); push_reads();
      run_op(1, 0, 0, "R4");
      chk(gaps_seen - d0 == 2, "R4 two CE gaps between handshakes", gaps_seen - d0, 2);
      chk(rd_sec == 8'h59 && rd_day == 8'h31 && rd_year == 8'h24 && rd_wday == 4'h6,
          "R7 read back after write", {rd_sec, rd_day, rd_year, rd_wday}, 28'h5931246);

      // R5: busy beyond the limit
      busy_left = 10;
      for (int i = 0; i < LIM; i++) push_pre();
      run_op(1, 0, 0, "R5");
      chk(op_error, "R5 error flagged at retry limit", op_error, 1);
      repeat (5) @(negedge clk);
      chk(op_error && !busy, "R2 error held until next start", {op_error, busy}, 2);
      busy_left = 0;

      // R2: starts during an operation are ignored
      d0 = done_seen;
      push_pre(); push_reads();
      @(negedge clk); start_read = 1;
      @(negedge clk); start_read = 0;
      repeat (20) @(negedge clk);
      start_write = 1; start_check = 1;
      @(negedge clk); start_write = 0; start_check = 0;
      wait_done("R2 ignore");
      repeat (6) @(negedge clk);
      chk(!busy && done_seen - d0 == 1, "R2 mid-operation starts ignored", {busy, 8'(done_seen - d0)}, 1);
      chk(exp_q.size() == 0 && !op_error, "R2 single read completed", exp_q.size(), 0);

      // R2: read and write together -> write wins
      set_wr(8'h41, 8'h37, 8'h09, 8'h15, 8'h11, 8'h03, 4'h2);
      push_pre(); push_writes(8'h41, 8'h37, 8'h09, 8'h15, 8'h11, 8'h03, 4'h2);
      run_op(1, 1, 0, "R2 priority");

      // R10: check with clock running
      xstp = 1'b0;
      push(0, 4'hE, 4'h0);
      run_op(0, 0, 1, "R10");
      chk(!reset_occurred && !op_error, "R10 no recovery when stop flag clear",
          {reset_occurred, op_error}, 0);

      // R11: stop flag set, restart busy for two polls; check also beats read
      xstp = 1'b1; adj_busy = 2; mreg[7] = 4'hF;
      push(0, 4'hE, 4'h0); push(1, 4'h7, 4'h0); push(1, 4'hE, 4'h7);
      push(0, 4'hE, 4'h0); push(0, 4'hE, 4'h0); push(0, 4'hE, 4'h0);
      push_writes(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 4'h0);
      run_op(1, 0, 1, "R11");
      chk(reset_occurred && !op_error, "R11 reset_occurred after recovery",
          {reset_occurred, op_error}, 2);
      chk(mreg[7] == 4'h0 && mreg[8] == 4'h1 && mreg[9] == 4'h0 && mreg[10] == 4'h1
          && mreg[0] == 4'h0 && mreg[13] == 4'h0, "R11 default date in device",
          {mreg[7], mreg[8], mreg[9], mreg[10], mreg[0], mreg[13]}, 24'h010100);
      chk(!rtc_ce && !bus_req, "R1 idle after check", {rtc_ce, bus_req}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule